// File: doc/BRIEF.md
# Delay Tap Step Router

This block sits between a read-calibration sequencer and the per-bit input delay lines of a data bus. The bus is split into equal lanes, each lane holding a fixed number of data bits that share one strobe. The sequencer issues a single shared command set: clear, step, and direction. The router decides which data bits receive that command. Its choice depends on the calibration phase, on whether bits are being tuned one at a time, and on the bit and lane indices the sequencer supplies.

For every data bit the router also keeps a shadow copy of the delay-line position, six bits wide. All shadow positions are exported on one flat bus. A step that would push any targeted position past the top or below zero is dropped for all bits. Such a step also sets a sticky range-error flag.

All outputs are registered. A command presented in one cycle shows up on the delay-line controls and in the shadow counts after the next rising clock edge. The sequencer must allow for that cycle before it samples the affected data.

Top module: `dly_tap_demux`

## Requirements
- R1: A step issued with `cmd_inc`=1 adds one to the shadow count of every bit it reaches. With `cmd_inc`=0 it subtracts one. For those bits `dq_dly_ce` goes high, and `dq_dly_inc` equals `cmd_inc`. Bits the step does not reach keep `dq_dly_ce`=0, `dq_dly_inc`=0 and their counts.
- R2: With `stage_done`=3'b000 (phase 1) and `per_bit_mode`=1, a step reaches only the bit numbered `bit_sel`.
- R3: With `stage_done`=3'b000 and `per_bit_mode`=0, a step reaches bits `grp_sel*BPG` through `grp_sel*BPG+BPG-1` together.
- R4: With `stage_done`=3'b001 (phase 2), a step reaches the whole lane `grp_sel`, whatever `per_bit_mode` is.
- R5: With `stage_done`=3'b011 (phase 3), 3'b111 (phase 4) or any other code, no step reaches any bit. `dq_dly_ce` stays zero and no count moves.
- R6: `cmd_rst`=1 drives every bit of `dq_dly_rst` high in the next cycle, whatever the indices are. It clears every shadow count to zero. It overrides a simultaneous step, which is then not issued.
- R7: If a step targets a bit whose count is 63 while incrementing, or 0 while decrementing, the whole step is dropped. No `dq_dly_ce` is raised and no count changes. `range_err` is set and stays set until block reset.
- R8: The shadow count of bit i appears on `tap_cnt_flat[6i+5:6i]`.
- R9: During and right after `rst`, all outputs are zero.
- R10: The outputs reflect the command from exactly one clock edge earlier. A cycle with `cmd_ce`=0 and `cmd_rst`=0 leaves `dq_dly_ce` and `dq_dly_rst` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow calibration clock |
| rst | input | 1 | Synchronous block reset, active high |
| stage_done | input | 3 | Progressive phase-completion bits |
| per_bit_mode | input | 1 | 1 = phase 1 tunes one bit at a time |
| bit_sel | input | $clog2(GROUPS*BPG) | Selected data bit |
| grp_sel | input | $clog2(GROUPS) | Selected lane |
| cmd_rst | input | 1 | Shared delay-line clear command |
| cmd_ce | input | 1 | Shared step command |
| cmd_inc | input | 1 | Step direction, 1 = add a tap |
| dq_dly_rst | output | GROUPS*BPG | Per-bit delay-line clear |
| dq_dly_ce | output | GROUPS*BPG | Per-bit step enable |
| dq_dly_inc | output | GROUPS*BPG | Per-bit step direction |
| tap_cnt_flat | output | 6*GROUPS*BPG | Shadow tap counts, 6 bits per bit |
| range_err | output | 1 | Sticky flag for a dropped out-of-range step |

## Verification
Routing is tested with commands spread across all phase codes, including an undefined one. Indices and direction are random. Comparing single-bit and whole-lane fan-out shows whether the phase and mode decode picks the right target set. Directed runs decrement a freshly cleared lane and increment a lane 64 times. These show that the range guard fires exactly at the boundary and drops the whole step. Clear commands mixed with steps confirm that clearing wins and reaches every bit, whatever the selection.

// File: rtl/dtd_pkg.sv
`timescale 1ns/1ps
package dtd_pkg;

  localparam int TAP_W = 6;

  typedef enum logic [2:0] {
    PH_ONE   = 3'd0,
    PH_TWO   = 3'd1,
    PH_THREE = 3'd2,
    PH_FOUR  = 3'd3,
    PH_NONE  = 3'd4
  } phase_e;

  // Progressive completion bits -> active phase
  function automatic phase_e phase_of(input logic [2:0] done);
    case (done)
      3'b000:  return PH_ONE;
      3'b001:  return PH_TWO;
      3'b011:  return PH_THREE;
      3'b111:  return PH_FOUR;
      default: return PH_NONE;
    endcase
  endfunction

  // True when a step in the given direction would leave the tap range
  function automatic logic tap_at_edge(input logic [TAP_W-1:0] cnt,
                                       input logic up);
    if (up) return (cnt == {TAP_W{1'b1}});
    return (cnt == '0);
  endfunction

  function automatic logic [TAP_W-1:0] tap_next(input logic [TAP_W-1:0] cnt,
                                                input logic up);
    if (up) return cnt + TAP_W'(1);
    return cnt - TAP_W'(1);
  endfunction

endpackage

// File: rtl/dtd_phase_decode.sv
`timescale 1ns/1ps
module dtd_phase_decode
  import dtd_pkg::*;
(
  input  logic [2:0] stage_done,
  input  logic       per_bit_mode,
  output phase_e     phase,
  output logic       route_bit,
  output logic       route_lane
);

  assign phase      = phase_of(stage_done);
  assign route_bit  = (phase == PH_ONE) && per_bit_mode;
  assign route_lane = ((phase == PH_ONE) && !per_bit_mode) || (phase == PH_TWO);

endmodule

// File: rtl/dtd_route.sv
`timescale 1ns/1ps
module dtd_route #(
  parameter  int GROUPS = 4,
  parameter  int BPG    = 8,
  localparam int DQ_W   = GROUPS * BPG,
  localparam int BIT_W  = (DQ_W > 1) ? $clog2(DQ_W) : 1,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic             route_bit,
  input  logic             route_lane,
  input  logic [BIT_W-1:0] bit_sel,
  input  logic [GRP_W-1:0] grp_sel,
  output logic [DQ_W-1:0]  target
);

  genvar gi;
  generate
    for (gi = 0; gi < DQ_W; gi++) begin : g_bit
      localparam int LANE = gi / BPG;
      logic hit_bit;
      logic hit_lane;
      assign hit_bit  = route_bit  && (bit_sel == BIT_W'(gi));
      assign hit_lane = route_lane && (grp_sel == GRP_W'(LANE));
      assign target[gi] = hit_bit || hit_lane;
    end
  endgenerate

endmodule

// File: rtl/dtd_tap_track.sv
`timescale 1ns/1ps
module dtd_tap_track
  import dtd_pkg::*;
#(
  parameter int DQ_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [DQ_W-1:0]       step,
  input  logic                  up,
  output logic [DQ_W-1:0]       at_edge,
  output logic [TAP_W*DQ_W-1:0] cnt_flat
);

  genvar gi;
  generate
    for (gi = 0; gi < DQ_W; gi++) begin : g_cnt
      logic [TAP_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (step[gi]) cnt_q <= tap_next(cnt_q, up);
      end
      assign at_edge[gi] = tap_at_edge(cnt_q, up);
      assign cnt_flat[TAP_W*gi +: TAP_W] = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/dly_tap_demux.sv
`timescale 1ns/1ps
module dly_tap_demux
  import dtd_pkg::*;
#(
  parameter  int GROUPS = 4,
  parameter  int BPG    = 8,
  localparam int DQ_W   = GROUPS * BPG,
  localparam int BIT_W  = (DQ_W > 1) ? $clog2(DQ_W) : 1,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            stage_done,
  input  logic                  per_bit_mode,
  input  logic [BIT_W-1:0]      bit_sel,
  input  logic [GRP_W-1:0]      grp_sel,
  input  logic                  cmd_rst,
  input  logic                  cmd_ce,
  input  logic                  cmd_inc,
  output logic [DQ_W-1:0]       dq_dly_rst,
  output logic [DQ_W-1:0]       dq_dly_ce,
  output logic [DQ_W-1:0]       dq_dly_inc,
  output logic [TAP_W*DQ_W-1:0] tap_cnt_flat,
  output logic                  range_err
);

  phase_e          phase;
  logic            route_bit;
  logic            route_lane;
  logic [DQ_W-1:0] target;
  logic [DQ_W-1:0] at_edge;
  logic [DQ_W-1:0] issue;

  // Named internal events, observed by the bound checker
  logic step_req;
  logic step_blocked;
  logic step_go;

  dtd_phase_decode u_dec (
    .stage_done  (stage_done),
    .per_bit_mode(per_bit_mode),
    .phase       (phase),
    .route_bit   (route_bit),
    .route_lane  (route_lane)
  );

  dtd_route #(.GROUPS(GROUPS), .BPG(BPG)) u_route (
    .route_bit (route_bit),
    .route_lane(route_lane),
    .bit_sel   (bit_sel),
    .grp_sel   (grp_sel),
    .target    (target)
  );

  assign step_req     = cmd_ce && !cmd_rst && (|target);
  assign step_blocked = step_req && (|(target & at_edge));
  assign step_go      = step_req && !step_blocked;
  assign issue        = target & {DQ_W{step_go}};

  dtd_tap_track #(.DQ_W(DQ_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .clr     (cmd_rst),
    .step    (issue),
    .up      (cmd_inc),
    .at_edge (at_edge),
    .cnt_flat(tap_cnt_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_dly_rst <= '0;
      dq_dly_ce  <= '0;
      dq_dly_inc <= '0;
      range_err  <= 1'b0;
    end else begin
      dq_dly_rst <= {DQ_W{cmd_rst}};
      dq_dly_ce  <= issue;
      dq_dly_inc <= issue & {DQ_W{cmd_inc}};
      if (step_blocked) range_err <= 1'b1;
    end
  end

endmodule

// File: rtl/dtd_checker.sv
`timescale 1ns/1ps
module dtd_checker #(
  parameter  int GROUPS = 4,
  parameter  int BPG    = 8,
  localparam int DQ_W   = GROUPS * BPG
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        stage_done,
  input logic              per_bit_mode,
  input logic              cmd_rst,
  input logic              cmd_ce,
  input logic [DQ_W-1:0]   dq_dly_rst,
  input logic [DQ_W-1:0]   dq_dly_ce,
  input logic [DQ_W-1:0]   dq_dly_inc,
  input logic [6*DQ_W-1:0] tap_cnt_flat,
  input logic              range_err,
  input logic              step_blocked,
  input logic              step_go
);

  a_r1_inc_within_ce: assert property (@(posedge clk) disable iff (rst)
    step_go |=> ((dq_dly_inc & ~dq_dly_ce) == '0) && (dq_dly_ce != '0));

  a_r2_single_bit: assert property (@(posedge clk) disable iff (rst)
    (stage_done == 3'b000 && per_bit_mode && cmd_ce) |=> $countones(dq_dly_ce) <= 1);

  a_r4_lane_bound: assert property (@(posedge clk) disable iff (rst)
    (stage_done == 3'b001) |=> $countones(dq_dly_ce) <= BPG);

  a_r5_late_phase_quiet: assert property (@(posedge clk) disable iff (rst)
    (stage_done == 3'b011 || stage_done == 3'b111) |=> dq_dly_ce == '0);

  a_r6_clear_broadcast: assert property (@(posedge clk) disable iff (rst)
    cmd_rst |=> (dq_dly_rst == {DQ_W{1'b1}}) && (dq_dly_ce == '0) && (tap_cnt_flat == '0));

  a_r7_block_drops_step: assert property (@(posedge clk) disable iff (rst)
    step_blocked |=> (dq_dly_ce == '0) && range_err && $stable(tap_cnt_flat));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    range_err |=> range_err);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ce && !cmd_rst) |=> (dq_dly_ce == '0) && (dq_dly_rst == '0));

endmodule

bind dly_tap_demux dtd_checker #(.GROUPS(GROUPS), .BPG(BPG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stage_done  (stage_done),
  .per_bit_mode(per_bit_mode),
  .cmd_rst     (cmd_rst),
  .cmd_ce      (cmd_ce),
  .dq_dly_rst  (dq_dly_rst),
  .dq_dly_ce   (dq_dly_ce),
  .dq_dly_inc  (dq_dly_inc),
  .tap_cnt_flat(tap_cnt_flat),
  .range_err   (range_err),
  .step_blocked(step_blocked),
  .step_go     (step_go)
);

// File: tb/dly_tap_demux_bench.sv
`timescale 1ns/1ps
module dly_tap_demux_bench;

  localparam int GROUPS = 4;
  localparam int BPG    = 8;
  localparam int DQ_W   = GROUPS * BPG;
  localparam int BIT_W  = $clog2(DQ_W);
  localparam int GRP_W  = $clog2(GROUPS);

  logic clk = 1'b0;
  logic rst;
  logic [2:0] stage_done;
  logic per_bit_mode;
  logic [BIT_W-1:0] bit_sel;
  logic [GRP_W-1:0] grp_sel;
  logic cmd_rst, cmd_ce, cmd_inc;
  logic [DQ_W-1:0] dq_dly_rst, dq_dly_ce, dq_dly_inc;
  logic [6*DQ_W-1:0] tap_cnt_flat;
  logic range_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int model_cnt [DQ_W];
  bit model_err;

  always #2 clk = ~clk;

  dly_tap_demux #(.GROUPS(GROUPS), .BPG(BPG)) u_dly_tap_demux (
    .clk(clk), .rst(rst), .stage_done(stage_done), .per_bit_mode(per_bit_mode),
    .bit_sel(bit_sel), .grp_sel(grp_sel), .cmd_rst(cmd_rst), .cmd_ce(cmd_ce),
    .cmd_inc(cmd_inc), .dq_dly_rst(dq_dly_rst), .dq_dly_ce(dq_dly_ce),
    .dq_dly_inc(dq_dly_inc), .tap_cnt_flat(tap_cnt_flat), .range_err(range_err)
  );

  function automatic logic [DQ_W-1:0] exp_target(logic [2:0] sd, bit pb, int b, int g);
    logic [DQ_W-1:0] m = '0;
    if (sd == 3'b000 && pb) m[b] = 1'b1;
    else if (sd == 3'b000 || sd == 3'b001)
      for (int k = 0; k < BPG; k++) m[g*BPG + k] = 1'b1;
    return m;
  endfunction

  function automatic logic [6*DQ_W-1:0] exp_flat();
    logic [6*DQ_W-1:0] f = '0;
    for (int i = 0; i < DQ_W; i++) f[6*i +: 6] = 6'(model_cnt[i]);
    return f;
  endfunction

  task automatic check_vec(string req, string what, logic [6*DQ_W-1:0] act,
                           logic [6*DQ_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [2:0] sd, bit pb, int b, int g, bit r, bit ce, bit inc);
    logic [DQ_W-1:0] tgt, e_ce, e_inc, e_rst;
    bit wrap, go;
    string req;
    stage_done = sd; per_bit_mode = pb; bit_sel = BIT_W'(b); grp_sel = GRP_W'(g);
    cmd_rst = r; cmd_ce = ce; cmd_inc = inc;
    tgt = exp_target(sd, pb, b, g);
    wrap = 0;
    for (int i = 0; i < DQ_W; i++)
      if (tgt[i] && ((inc && model_cnt[i] == 63) || (!inc && model_cnt[i] == 0))) wrap = 1;
    go = ce && !r && (tgt != '0) && !wrap;
    if (ce && !r && (tgt != '0) && wrap) model_err = 1;
    e_ce  = go ? tgt : '0;
    e_inc = (go && inc) ? tgt : '0;
    e_rst = r ? '1 : '0;
    for (int i = 0; i < DQ_W; i++) begin
      if (r) model_cnt[i] = 0;
      else if (e_ce[i]) model_cnt[i] = inc ? model_cnt[i] + 1 : model_cnt[i] - 1;
    end
    if (r) req = "R6";
    else if (ce && wrap && tgt != '0) req = "R7";
    else if (!ce) req = "R10";
    else if (sd == 3'b000 && pb) req = "R2";
    else if (sd == 3'b000) req = "R3";
    else if (sd == 3'b001) req = "R4";
    else req = "R5";
    @(posedge clk);
    @(negedge clk);
    check_vec(req, "dq_dly_ce", (6*DQ_W)'(dq_dly_ce), (6*DQ_W)'(e_ce));
    check_vec("R1", "dq_dly_inc", (6*DQ_W)'(dq_dly_inc), (6*DQ_W)'(e_inc));
    check_vec("R6", "dq_dly_rst", (6*DQ_W)'(dq_dly_rst), (6*DQ_W)'(e_rst));
    check_vec("R8", "tap_cnt_flat", tap_cnt_flat, exp_flat());
    check_vec("R7", "range_err", (6*DQ_W)'(range_err), (6*DQ_W)'(model_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    for (int i = 0; i < DQ_W; i++) model_cnt[i] = 0;
    model_err = 0;
    rst = 1; stage_done = 0; per_bit_mode = 0; bit_sel = 0; grp_sel = 0;
    cmd_rst = 0; cmd_ce = 0; cmd_inc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check_vec("R9", "dq_dly_ce", (6*DQ_W)'(dq_dly_ce), '0);
    check_vec("R9", "dq_dly_rst", (6*DQ_W)'(dq_dly_rst), '0);
    check_vec("R9", "tap_cnt_flat", tap_cnt_flat, '0);
    check_vec("R9", "range_err", (6*DQ_W)'(range_err), '0);
    rst = 0;

    // R2: single-bit steps
    for (int k = 0; k < 3; k++) step(3'b000, 1, 5, 0, 0, 1, 1);
    step(3'b000, 1, 5, 0, 0, 1, 0);
    step(3'b000, 1, 31, 3, 0, 0, 1);           // R10 idle
    // R7: underflow on cleared lane 1 in phase 2
    step(3'b001, 0, 0, 1, 0, 1, 0);
    // R3: phase 1 lane mode
    step(3'b000, 0, 0, 2, 0, 1, 1);
    step(3'b000, 0, 9, 2, 0, 1, 1);
    // R4: phase 2 ignores per-bit mode
    step(3'b001, 1, 2, 0, 0, 1, 1);
    // R5: late phases and undefined code
    step(3'b011, 0, 3, 0, 0, 1, 1);
    step(3'b111, 1, 5, 0, 0, 1, 0);
    step(3'b010, 0, 3, 2, 0, 1, 1);
    // R6: clear wins over a step
    step(3'b000, 1, 5, 0, 1, 1, 1);
    // R7: overflow, 64th increment on lane 3 is dropped
    for (int k = 0; k < 64; k++) step(3'b001, 0, 0, 3, 0, 1, 1);
    step(3'b001, 0, 0, 3, 0, 1, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] sd;
      int pick = $urandom_range(0, 9);
      sd = (pick < 4) ? 3'b000 : (pick < 7) ? 3'b001 : (pick == 7) ? 3'b011 :
           (pick == 8) ? 3'b111 : 3'(($urandom_range(0, 1) == 1) ? 3'b010 : 3'b101);
      step(sd, bit'($urandom_range(0, 1)), $urandom_range(0, DQ_W-1),
           $urandom_range(0, GROUPS-1), ($urandom_range(0, 99) < 2),
           ($urandom_range(0, 9) < 7), ($urandom_range(0, 9) < 6));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule